// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers up to 32 peripheral interrupt lines into one parent interrupt for a processor's first-level controller. Each source has one bit in every register. A per-bit mask decides which sources can drive the parent line. The parent output is high whenever at least one status bit is set and its mask bit is clear. Software reaches the block through a simple single-cycle register port. Read data is combinational: it is valid in the same cycle as a select with write low.

A build parameter picks one of two variants. The latched variant records rising edges into sticky status bits, and software clears them through a write-one-to-clear register. The level variant shows the live synchronized input levels as status and has no clear register, so its mask registers sit at lower offsets. In both variants the mask changes only through two strobe registers, one that sets mask bits and one that clears them. Every input crosses a two-flop synchronizer before it is used.

Top module: `l2irq_ctrl`

## Requirements
- R1: After reset the mask reads all ones (all sources disabled), every status bit reads 0 and irq_out is 0.
- R2: A write to the mask-set register (offset 0x10 latched, 0x08 level) sets each mask bit whose data bit is 1; data bits of 0 leave the mask unchanged.
- R3: A write to the mask-clear register (offset 0x14 latched, 0x0C level) clears each mask bit whose data bit is 1; data bits of 0 leave the mask unchanged.
- R4: A read of the mask-status register (offset 0x0C latched, 0x04 level) returns the current mask, where 1 means disabled; read data is valid in the cycle of the read strobe.
- R5: irq_out is 1 exactly when some status bit is 1 while its mask bit is 0.
- R6: Latched variant: a rising input edge sets its status bit (offset 0x00) even while the source is masked, and the bit stays set after the input falls. An input raised before clock edge k is visible in status after edge k+2.
- R7: Latched variant: a write to the clear register (offset 0x08) clears each status bit whose data bit is 1; data bits of 0 have no effect.
- R8: Latched variant: when a new edge reaches a status bit in the same cycle as a clear write to that bit, the bit remains set.
- R9: Level variant: status (offset 0x00) equals the input levels delayed by two clock edges, and writes to offset 0x00 or to any unmapped offset change neither status nor mask.
- R10: Reads of unmapped offsets return zero, and the mask changes only on writes to its set or clear register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Peripheral interrupt lines, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data, combinational from bus_addr |
| irq_out | output | 1 | Parent interrupt request |

## Verification
The assertions take for granted that the bus carries one access per cycle and that bus_addr and bus_wdata are stable while bus_sel is high. They also assume irq_in may change at any time, since every input passes through the synchronizer first. The bench drives all bus and interrupt signals only on falling clock edges and samples results a little later. It also lines up the clear write with the edge arrival to the exact cycle, so the collision case is checked directly and not by chance.

// File: rtl/l2irq_pkg.sv
// Package: register kinds and the offset decode shared by the
// controller and its checker. Assumes byte offsets, word aligned.
package l2irq_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STATUS,
        RK_CLEAR,
        RK_MSTAT,
        RK_MSET,
        RK_MCLR
    } reg_kind_e;

    // Map a byte offset to a register kind for the chosen variant.
    function automatic reg_kind_e decode_offset(input logic [31:0] off,
                                                input bit latched);
        reg_kind_e k;
        k = RK_NONE;
        if (latched) begin
            case (off)
                32'h00: k = RK_STATUS;
                32'h08: k = RK_CLEAR;
                32'h0C: k = RK_MSTAT;
                32'h10: k = RK_MSET;
                32'h14: k = RK_MCLR;
                default: k = RK_NONE;
            endcase
        end else begin
            case (off)
                32'h00: k = RK_STATUS;
                32'h04: k = RK_MSTAT;
                32'h08: k = RK_MSET;
                32'h0C: k = RK_MCLR;
                default: k = RK_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/l2irq_sync.sv
// Multi-flop synchronizer for a vector of asynchronous lines.
// Assumes each line is held long enough to be sampled; no pulse
// stretching. Reset clears every stage.
module l2irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw lines.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            // Later stages resample the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/l2irq_status.sv
// Status store. LATCHED=1: sticky bits set by rising edges of the
// synchronized inputs and cleared by a write-one-to-clear vector,
// a new edge winning over a clear. LATCHED=0: status is the
// synchronized level and the clear vector is not used.
module l2irq_status #(
    parameter int WIDTH   = 32,
    parameter bit LATCHED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] stat_o
);
    if (LATCHED) begin : g_latched
        logic [WIDTH-1:0] prev_q;
        logic [WIDTH-1:0] stat_q;
        logic [WIDTH-1:0] rise;

        assign rise = lvl_i & ~prev_q;

        // Remember last synchronized level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= lvl_i;
        end

        // Clear requested bits, then let fresh edges set them again.
        always_ff @(posedge clk) begin
            if (!rst_n) stat_q <= '0;
            else        stat_q <= (stat_q & ~clr_i) | rise;
        end

        assign stat_o = stat_q;
    end else begin : g_level
        assign stat_o = lvl_i;
    end
endmodule

// File: rtl/l2irq_mask.sv
// Mask register with separate set and clear strobe vectors.
// Assumes set and clear are never both nonzero in one cycle (they
// come from different offsets). Resets to all ones (all disabled).
module l2irq_mask #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] mask_o
);
    logic [WIDTH-1:0] mask_q;

    // Apply set bits, then clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= (mask_q | set_i) & ~clr_i;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/l2irq_ctrl.sv
// Second-level interrupt aggregator top. Decodes the register port,
// routes strobes to the mask and status stores, muxes read data and
// forms the parent request. Assumes one access per cycle and
// ADDR_W of at least 5 bits to reach every offset.
module l2irq_ctrl #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 5,
    parameter bit LATCHED = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               irq_out
);
    import l2irq_pkg::*;

    localparam logic [NUM_SRC-1:0] NONE_V = '0;

    reg_kind_e        kind;
    logic             wr_hit;
    logic [NUM_SRC-1:0] lvl_sync;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] mclr_v;
    logic [NUM_SRC-1:0] sclr_v;

    assign kind   = decode_offset(32'(bus_addr), LATCHED);
    assign wr_hit = bus_sel && bus_wr;

    // Turn a write into per-register strobe vectors.
    always_comb begin
        set_v  = NONE_V;
        mclr_v = NONE_V;
        sclr_v = NONE_V;
        if (wr_hit) begin
            case (kind)
                RK_MSET:  set_v  = bus_wdata;
                RK_MCLR:  mclr_v = bus_wdata;
                RK_CLEAR: sclr_v = bus_wdata;
                default:  ;
            endcase
        end
    end

    l2irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_in),
        .q_o   (lvl_sync)
    );

    l2irq_status #(.WIDTH(NUM_SRC), .LATCHED(LATCHED)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_sync),
        .clr_i  (sclr_v),
        .stat_o (stat_q)
    );

    l2irq_mask #(.WIDTH(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (mclr_v),
        .mask_o (mask_q)
    );

    // Read mux: status or mask, zero for anything else.
    always_comb begin
        bus_rdata = NONE_V;
        if (bus_sel && !bus_wr) begin
            case (kind)
                RK_STATUS: bus_rdata = stat_q;
                RK_MSTAT:  bus_rdata = mask_q;
                default:   bus_rdata = NONE_V;
            endcase
        end
    end

    // Parent request from any pending, enabled source.
    assign irq_out = |(stat_q & ~mask_q);
endmodule

// File: rtl/l2irq_ctrl_chk.sv
// Checker for l2irq_ctrl, bound to every instance. Observes ports
// plus the status and mask stores driven by separate submodules.
module l2irq_ctrl_chk #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 5,
    parameter bit LATCHED = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic [NUM_SRC-1:0] bus_rdata,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] stat_q,
    input logic [NUM_SRC-1:0] mask_q
);
    import l2irq_pkg::*;

    reg_kind_e k;
    logic      rd_hit;
    logic      wr_hit;
    logic [NUM_SRC-1:0] clr_req;

    assign k       = decode_offset(32'(bus_addr), LATCHED);
    assign rd_hit  = bus_sel && !bus_wr;
    assign wr_hit  = bus_sel && bus_wr;
    assign clr_req = (wr_hit && k == RK_CLEAR) ? bus_wdata : '0;

    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && k == RK_MSET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && k == RK_MCLR) |=> ((mask_q & $past(bus_wdata)) == '0));

    p_mstat_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && k == RK_MSTAT) |-> (bus_rdata == mask_q));

    p_all_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq_out);

    p_no_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq_out);

    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && k == RK_NONE) |-> (bus_rdata == '0));

    p_mask_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && (k == RK_MSET || k == RK_MCLR)) |=> $stable(mask_q));

    if (LATCHED) begin : g_latched_chk
        // R6/R7: a sticky bit drops only where a clear was written.
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (|stat_q) |=> (($past(stat_q) & ~stat_q & ~$past(clr_req)) == '0));
    end
endmodule

bind l2irq_ctrl l2irq_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .LATCHED (LATCHED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .stat_q    (stat_q),
    .mask_q    (mask_q)
);

// File: tb/tb_l2irq_ctrl.sv
// Directed bench: instance dut is the latched variant, dut_lvl the
// level variant. Inputs change on falling edges; results are read
// shortly after falling edges.
module tb_l2irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_a = '0;
    logic [31:0] irq_b = '0;
    logic        sel_a = 1'b0;
    logic        sel_b = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_a;
    logic [31:0] rd_b;
    logic        int_a;
    logic        int_b;
    int          checks = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    l2irq_ctrl #(.LATCHED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_a), .bus_sel(sel_a),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd_a), .irq_out(int_a)
    );

    l2irq_ctrl #(.LATCHED(1'b0)) dut_lvl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_b), .bus_sel(sel_b),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd_b), .irq_out(int_b)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input bit lvl, input logic [4:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        sel_a = !lvl; sel_b = lvl; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; wr = 1'b0;
    endtask

    task automatic bread(input bit lvl, input logic [4:0] a,
                         output logic [31:0] d);
        @(negedge clk);
        sel_a = !lvl; sel_b = lvl; wr = 1'b0; addr = a;
        #1;
        d = lvl ? rd_b : rd_a;
        sel_a = 1'b0; sel_b = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bread(0, 5'h0C, d); chk("R1 latched mask", d, 32'hFFFF_FFFF);
        bread(0, 5'h00, d); chk("R1 latched status", d, 32'h0);
        chk("R1 latched irq_out", {31'b0, int_a}, 32'h0);
        bread(1, 5'h04, d); chk("R1 level mask", d, 32'hFFFF_FFFF);
        chk("R1 level irq_out", {31'b0, int_b}, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        bwrite(0, 5'h14, 32'h0000_00F0);
        bread(0, 5'h0C, d); chk("R3 mask clear", d, 32'hFFFF_FF0F);
        bwrite(0, 5'h10, 32'h0000_0010);
        bread(0, 5'h0C, d); chk("R2 mask set", d, 32'hFFFF_FF1F);
        bwrite(0, 5'h10, 32'h0);
        bread(0, 5'h0C, d); chk("R2 zero set bits", d, 32'hFFFF_FF1F);
        bwrite(0, 5'h14, 32'h0);
        bread(0, 5'h0C, d); chk("R3 zero clear bits", d, 32'hFFFF_FF1F);
        bwrite(0, 5'h10, 32'hFFFF_FFFF);
        bread(0, 5'h0C, d); chk("R4 mask readback", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        @(negedge clk); irq_a[3] = 1'b1;
        bread(0, 5'h00, d); chk("R6 latency edge k", d, 32'h0);
        bread(0, 5'h00, d); chk("R6 latency edge k+1", d, 32'h0);
        bread(0, 5'h00, d); chk("R6 set while masked", d, 32'h8);
        chk("R5 masked no irq", {31'b0, int_a}, 32'h0);
        @(negedge clk); irq_a[3] = 1'b0;
        repeat (3) @(negedge clk);
        bread(0, 5'h00, d); chk("R6 sticky after fall", d, 32'h8);
        bwrite(0, 5'h14, 32'h8);
        chk("R5 unmasked irq", {31'b0, int_a}, 32'h1);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        bwrite(0, 5'h08, 32'h0);
        bread(0, 5'h00, d); chk("R7 zero clear bits", d, 32'h8);
        bwrite(0, 5'h08, 32'h8);
        bread(0, 5'h00, d); chk("R7 clear", d, 32'h0);
        chk("R5 irq drops", {31'b0, int_a}, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        @(negedge clk); irq_a[1] = 1'b1;
        repeat (4) @(negedge clk);
        irq_a[1] = 1'b0;
        bread(0, 5'h00, d); chk("R6 second source", d, 32'h2);
        @(negedge clk); irq_a[5] = 1'b1;
        @(negedge clk);
        bwrite(0, 5'h08, 32'h0000_0022);
        bread(0, 5'h00, d); chk("R8 edge beats clear", d, 32'h20);
        irq_a[5] = 1'b0;
        bwrite(0, 5'h08, 32'h20);
        bread(0, 5'h04, d); chk("R10 unmapped 0x04", d, 32'h0);
        bread(0, 5'h18, d); chk("R10 unmapped 0x18", d, 32'h0);
        bwrite(0, 5'h1C, 32'hFFFF_FFFF);
        bread(0, 5'h0C, d); chk("R10 unmapped write", d, 32'hFFFF_FFF7);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); irq_b = 32'h0000_0081;
        bread(1, 5'h00, d); chk("R9 level edge k", d, 32'h0);
        bread(1, 5'h00, d); chk("R9 level two edges", d, 32'h81);
        chk("R5 level masked", {31'b0, int_b}, 32'h0);
        bwrite(1, 5'h0C, 32'h80);
        bread(1, 5'h04, d); chk("R3 level mask clear", d, 32'hFFFF_FF7F);
        chk("R5 level irq", {31'b0, int_b}, 32'h1);
        bwrite(1, 5'h00, 32'hFFFF_FFFF);
        bwrite(1, 5'h14, 32'hFFFF_FFFF);
        bread(1, 5'h00, d); chk("R9 writes ignored status", d, 32'h81);
        bread(1, 5'h04, d); chk("R9 writes ignored mask", d, 32'hFFFF_FF7F);
        bwrite(1, 5'h08, 32'h80);
        chk("R2 level mask set", {31'b0, int_b}, 32'h0);
        @(negedge clk); irq_b = 32'h0;
        repeat (2) @(negedge clk);
        bread(1, 5'h00, d); chk("R9 level follows fall", d, 32'h0);
        bread(1, 5'h10, d); chk("R10 level unmapped", d, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_latch();
        t_clear();
        t_collide();
        t_level();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule